// File: doc/BRIEF.md
# Audio Sample Byte Packer

This block sits between an audio serial receiver and a memory write port. Each time the receiver presents a left/right sample pair (16-bit, left-adjusted), the packer turns it into a short stream of bytes, each tagged with a relative byte address. The stream can be consumed by a memory writer through a valid/ready handshake.

Four storage layouts are supported: one byte per period (mono, 8-bit), two bytes alternating left then right (stereo, 8-bit), two bytes per left sample (mono, 16-bit) and four bytes per period holding left then right (stereo, 16-bit). In the 16-bit layouts a control bit picks the byte order. The 8-bit layouts keep only the upper byte of each sample. Bytes always go out in rising address order.

A start pulse rewinds the address to zero, discards any bytes still waiting and clears the overrun flag. A pair that arrives while the previous one is still draining is dropped, and the overrun flag is raised.

Top module: `sample_byte_packer`

## Requirements
- R1: After reset, out_valid is 0, out_addr is 0 and overrun is 0.
- R2: With fmt_sel=0 (mono, 8-bit), each pair yields one byte, in_left[15:8]. Each pair uses the next address, so the address steps by 1 per sample.
- R3: With fmt_sel=1 (stereo, 8-bit), each pair yields in_left[15:8] at address A, then in_right[15:8] at A+1.
- R4: With fmt_sel=2 (mono, 16-bit), each pair yields the two bytes of in_left at A and A+1. The next sample starts at A+2.
- R5: With fmt_sel=3 (stereo, 16-bit), the left sample takes A and A+1 and the right sample takes A+2 and A+3. The next pair starts at A+4.
- R6: In the 16-bit formats, little_end=1 puts the low byte at the lower address and little_end=0 puts the high byte there. In the 8-bit formats, little_end has no effect.
- R7: While out_valid=1 and out_ready=0, out_valid, out_data and out_addr hold steady. out_addr advances by exactly 1 per accepted byte.
- R8: A pair presented while out_valid=1 is dropped and sets overrun. Overrun stays set until start or reset. The bytes of the pair being drained are delivered unchanged.
- R9: A start pulse sets out_addr to 0, discards any undelivered bytes and clears overrun. An in_valid in the same cycle is ignored.
- R10: fmt_sel and little_end are captured together with the pair. Changing them while the pair drains does not change its bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Rewind address, flush, clear overrun |
| fmt_sel | input | 2 | Layout: 0 mono8, 1 stereo8, 2 mono16, 3 stereo16 |
| little_end | input | 1 | Byte order of 16-bit samples (1 = low byte first) |
| in_valid | input | 1 | Sample pair present (one-cycle strobe) |
| in_left | input | SAMPLE_W | Left sample, left-adjusted |
| in_right | input | SAMPLE_W | Right sample, left-adjusted |
| out_valid | output | 1 | Byte available |
| out_ready | input | 1 | Byte taken this cycle when out_valid=1 |
| out_data | output | 8 | Byte value |
| out_addr | output | ADDR_W | Relative byte address |
| overrun | output | 1 | Sticky flag: a pair was dropped |

## Verification
The bench builds the block with its defaults: 16-bit samples and a 16-bit address. With these values every byte lane of both samples can be seen directly on out_data, under both byte orders. Because the address stays far from wrap, address continuity can be followed across several pairs and format changes, and the bench tracks the expected address itself. Back-pressure is held long enough to land a second pair on a busy packer, and a start pulse is fired while bytes are still pending.

// File: rtl/pk_pkg.sv
package pk_pkg;
    localparam int SAMPLE_W = 16;
    localparam int BYTE_W   = 8;
    localparam int IDX_W    = 2;

    typedef enum logic [1:0] {
        FMT_MONO8   = 2'd0,
        FMT_STEREO8 = 2'd1,
        FMT_MONO16  = 2'd2,
        FMT_STEREO16= 2'd3
    } fmt_e;

    typedef struct packed {
        logic [SAMPLE_W-1:0] left;
        logic [SAMPLE_W-1:0] right;
        fmt_e                fmt;
        logic                little;
    } pair_t;

    function automatic logic [IDX_W:0] bytes_in_pair(fmt_e f);
        case (f)
            FMT_MONO8:   return 3'd1;
            FMT_STEREO8: return 3'd2;
            FMT_MONO16:  return 3'd2;
            default:     return 3'd4;
        endcase
    endfunction

    function automatic logic is_wide(fmt_e f);
        return (f == FMT_MONO16) || (f == FMT_STEREO16);
    endfunction

    // Which byte of the held pair goes out at stream position idx.
    function automatic logic [BYTE_W-1:0] pick_byte(pair_t p, logic [IDX_W-1:0] idx);
        logic                use_right;
        logic                upper;
        logic [SAMPLE_W-1:0] s;
        if (is_wide(p.fmt)) begin
            use_right = idx[1];
            upper     = idx[0] ^ ~p.little;
        end else begin
            use_right = idx[0];
            upper     = 1'b1;
        end
        s = use_right ? p.right : p.left;
        return upper ? s[SAMPLE_W-1 -: BYTE_W] : s[SAMPLE_W-BYTE_W-1 -: BYTE_W];
    endfunction
endpackage

// File: rtl/pk_capture.sv
module pk_capture
    import pk_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  logic  in_valid,
    input  pair_t in_pair,
    input  logic  drain_done,
    output pair_t held,
    output logic  busy,
    output logic  overrun
);
    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            overrun <= 1'b0;
            held    <= '0;
        end else if (start) begin
            busy    <= 1'b0;
            overrun <= 1'b0;
        end else begin
            if (in_valid && !busy) begin
                held <= in_pair;
                busy <= 1'b1;
            end else if (drain_done) begin
                busy <= 1'b0;
            end
            if (in_valid && busy)
                overrun <= 1'b1;
        end
    end

    // R8: a pair landing on a busy packer raises the flag
    p_drop_flags_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && busy && !start) |=> overrun);

    // R8: held pair is not replaced while busy
    p_held_kept_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && !start) |=> $stable(held));

    // R9: start empties and clears
    p_start_clears_r9: assert property (@(posedge clk) disable iff (rst)
        start |=> (!busy && !overrun));
endmodule

// File: rtl/pk_sequencer.sv
module pk_sequencer
    import pk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              busy,
    input  pair_t             held,
    input  logic              fire,
    output logic [BYTE_W-1:0] data,
    output logic              last
);
    logic [IDX_W-1:0] idx;
    logic [IDX_W:0]   count;

    assign count = bytes_in_pair(held.fmt);
    assign last  = ({1'b0, idx} == count - 1'b1);
    assign data  = pick_byte(held, idx);

    always_ff @(posedge clk) begin
        if (rst || start)
            idx <= '0;
        else if (fire)
            idx <= last ? '0 : idx + 1'b1;
    end

    // R5: stream position never runs past the pair size
    p_idx_bound_r5: assert property (@(posedge clk) disable iff (rst)
        busy |-> ({1'b0, idx} < count));

    // R7: position stays put without a handshake
    p_idx_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && !fire && !start) |=> $stable(idx));
endmodule

// File: rtl/pk_addr.sv
module pk_addr #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              fire,
    output logic [ADDR_W-1:0] addr
);
    always_ff @(posedge clk) begin
        if (rst || start)
            addr <= '0;
        else if (fire)
            addr <= addr + 1'b1;
    end

    // R7: one step per accepted byte
    p_addr_step_r7: assert property (@(posedge clk) disable iff (rst)
        (fire && !start) |=> (addr == $past(addr) + 1'b1));

    // R9: start rewinds
    p_addr_zero_r9: assert property (@(posedge clk) disable iff (rst)
        start |=> (addr == '0));
endmodule

// File: rtl/sample_byte_packer.sv
module sample_byte_packer
    import pk_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [1:0]          fmt_sel,
    input  logic                little_end,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_left,
    input  logic [SAMPLE_W-1:0] in_right,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [BYTE_W-1:0]   out_data,
    output logic [ADDR_W-1:0]   out_addr,
    output logic                overrun
);
    pair_t in_pair;
    pair_t held;
    logic  busy;
    logic  last;
    logic  fire;

    assign in_pair = '{left: in_left, right: in_right, fmt: fmt_e'(fmt_sel), little: little_end};
    assign fire      = busy && out_ready;
    assign out_valid = busy;

    pk_capture u_cap (
        .clk(clk), .rst(rst), .start(start), .in_valid(in_valid),
        .in_pair(in_pair), .drain_done(fire && last),
        .held(held), .busy(busy), .overrun(overrun)
    );

    pk_sequencer u_seq (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .held(held),
        .fire(fire), .data(out_data), .last(last)
    );

    pk_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk(clk), .rst(rst), .start(start), .fire(fire), .addr(out_addr)
    );

    // R7: a stalled byte stays unchanged at the port
    p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && !start) |=> (out_valid && $stable(out_data) && $stable(out_addr)));
endmodule

// File: tb/test_sample_byte_packer.sv
module test_sample_byte_packer;
    logic        clk = 1'b0;
    logic        rst, start, little_end, in_valid, out_ready;
    logic [1:0]  fmt_sel;
    logic [15:0] in_left, in_right;
    logic        out_valid, overrun;
    logic [7:0]  out_data;
    logic [15:0] out_addr;

    int checks = 0;
    int errors = 0;
    int exp_addr = 0;
    bit done = 0;

    always #10 clk = ~clk;

    sample_byte_packer i_sample_byte_packer (
        .clk(clk), .rst(rst), .start(start), .fmt_sel(fmt_sel),
        .little_end(little_end), .in_valid(in_valid), .in_left(in_left),
        .in_right(in_right), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_addr(out_addr), .overrun(overrun)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(int f, bit le, logic [15:0] l, logic [15:0] r);
        @(negedge clk);
        fmt_sel = f[1:0]; little_end = le; in_left = l; in_right = r; in_valid = 1;
        @(negedge clk);
        in_valid = 0;
    endtask

    task automatic do_start();
        @(negedge clk);
        start = 1;
        @(negedge clk);
        start = 0;
        exp_addr = 0;
    endtask

    // Expects the next byte; out_ready is assumed high, so it is consumed at the next edge.
    task automatic expect_byte(string req, logic [7:0] d);
        int n = 0;
        while (!out_valid && n < 20) begin
            @(negedge clk);
            n++;
        end
        check({req, " valid"}, out_valid, 1);
        check({req, " data"}, out_data, d);
        check({req, " addr"}, out_addr, exp_addr);
        exp_addr++;
        @(negedge clk);
    endtask

    task automatic expect_idle(string req);
        @(negedge clk);
        check({req, " idle"}, out_valid, 0);
    endtask

    task automatic t_reset();
        check("R1 valid", out_valid, 0);
        check("R1 addr", out_addr, 0);
        check("R1 overrun", overrun, 0);
    endtask

    task automatic t_mono8();
        send(0, 0, 16'hA53C, 16'h1111);
        expect_byte("R2 m8 first", 8'hA5);
        send(0, 0, 16'h7E01, 16'h2222);
        expect_byte("R2 m8 second", 8'h7E);
        send(0, 1, 16'hC30F, 16'h3333);
        expect_byte("R6 m8 little ignored", 8'hC3);
        expect_idle("R2");
    endtask

    task automatic t_stereo8();
        do_start();
        send(1, 1, 16'h1234, 16'hABCD);
        expect_byte("R3 s8 left", 8'h12);
        expect_byte("R3 s8 right", 8'hAB);
        expect_idle("R3");
    endtask

    task automatic t_mono16();
        do_start();
        send(2, 1, 16'hBEEF, 16'h0);
        expect_byte("R4 m16 le lo", 8'hEF);
        expect_byte("R4 m16 le hi", 8'hBE);
        send(2, 1, 16'h1357, 16'h0);
        expect_byte("R4 m16 next lo", 8'h57);
        expect_byte("R4 m16 next hi", 8'h13);
        do_start();
        send(2, 0, 16'hBEEF, 16'h0);
        expect_byte("R6 m16 be hi", 8'hBE);
        expect_byte("R6 m16 be lo", 8'hEF);
    endtask

    task automatic t_stereo16();
        do_start();
        send(3, 1, 16'h1122, 16'h3344);
        expect_byte("R5 s16 L lo", 8'h22);
        expect_byte("R5 s16 L hi", 8'h11);
        expect_byte("R5 s16 R lo", 8'h44);
        expect_byte("R5 s16 R hi", 8'h33);
        send(3, 0, 16'h5566, 16'h7788);
        expect_byte("R6 s16 be L hi", 8'h55);
        expect_byte("R6 s16 be L lo", 8'h66);
        expect_byte("R6 s16 be R hi", 8'h77);
        expect_byte("R6 s16 be R lo", 8'h88);
        expect_idle("R5");
    endtask

    task automatic t_stall();
        do_start();
        out_ready = 0;
        send(3, 0, 16'hA1B2, 16'hC3D4);
        repeat (4) begin
            check("R7 stall valid", out_valid, 1);
            check("R7 stall data", out_data, 8'hA1);
            check("R7 stall addr", out_addr, 0);
            @(negedge clk);
        end
        out_ready = 1;
        expect_byte("R7 resume 0", 8'hA1);
        expect_byte("R7 resume 1", 8'hB2);
        expect_byte("R7 resume 2", 8'hC3);
        expect_byte("R7 resume 3", 8'hD4);
    endtask

    task automatic t_overrun();
        do_start();
        out_ready = 0;
        send(1, 0, 16'h4400, 16'h5500);
        send(1, 0, 16'h6600, 16'h7700);
        check("R8 overrun set", overrun, 1);
        out_ready = 1;
        expect_byte("R8 kept left", 8'h44);
        expect_byte("R8 kept right", 8'h55);
        expect_idle("R8 dropped pair");
        check("R8 sticky", overrun, 1);
    endtask

    task automatic t_start();
        out_ready = 0;
        send(3, 0, 16'h9999, 16'h8888);
        @(negedge clk);
        start = 1; in_valid = 1; in_left = 16'h4242;
        @(negedge clk);
        start = 0; in_valid = 0;
        exp_addr = 0;
        check("R9 flushed", out_valid, 0);
        check("R9 addr zero", out_addr, 0);
        check("R9 overrun clear", overrun, 0);
        out_ready = 1;
        expect_idle("R9 same-cycle pair ignored");
    endtask

    task automatic t_latch();
        do_start();
        out_ready = 0;
        send(2, 1, 16'hF00D, 16'h0);
        @(negedge clk);
        fmt_sel = 0; little_end = 0;
        @(negedge clk);
        out_ready = 1;
        expect_byte("R10 latched lo", 8'h0D);
        expect_byte("R10 latched hi", 8'hF0);
        expect_idle("R10");
    endtask

    initial begin
        rst = 1; start = 0; fmt_sel = 0; little_end = 0; in_valid = 0;
        in_left = 0; in_right = 0; out_ready = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_mono8();
        t_stereo8();
        t_mono16();
        t_stereo16();
        t_stall();
        t_overrun();
        t_start();
        t_latch();
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule